// File: doc/BRIEF.md
# Read Data Parity Checker

This block watches the data returned on a processor's read bus and checks each byte lane against its own parity bit, using even parity. A lane takes part only when its byte enable marks it as carrying valid data, and only in a clock where the ready strobe accepts a read transfer. The result comes out on an active-low check output exactly two clocks after that ready clock. The check runs as a two-stage pipeline, so every transfer gets its own result, even when transfers arrive back to back.

When an error is found and the parity-enable input is high in that same clock, the block records the address and control of the failing cycle in a pair of machine-check registers and sets a valid flag. The first record is kept until software clears the flag. If the machine-check-enable configuration bit is also set, the block raises a one-clock machine-check request.

Top module: `rd_parity_chk`

## Requirements
- R1: Lane i is data bits [8i+7:8i] with parity bit i. The lane is in error when the XOR of its eight data bits and its parity bit is 1 (even parity).
- R2: `pchk_n_o` is 0 in the second clock after a clock in which an error was detected. It is 1 in every other clock.
- R3: A lane whose `byte_en_i` bit is 0 never causes an error, whatever its data and parity.
- R4: A clock with `rd_i` = 0 (write) or `rdy_i` = 0 never causes an error.
- R5: Errors in consecutive ready clocks give consecutive low clocks on `pchk_n_o`, one for each error clock.
- R6: An error with `par_en_i` = 1 while the valid flag is 0 loads `addr_i` and `ctl_i` into the machine-check registers and sets `mc_valid_o` from the next clock.
- R7: An error with `par_en_i` = 0 captures nothing and leaves the valid flag and the registers unchanged.
- R8: While `mc_valid_o` is 1 and no clear is given, later errors do not change the machine-check registers.
- R9: `mc_clr_i` = 1 clears `mc_valid_o` in the next clock. If a capturing error happens in the same clock, the new cycle is loaded and the valid flag stays 1.
- R10: `mc_req_o` is 1 for exactly the clock after an error clock in which both `par_en_i` and `mce_i` are 1, whether or not the flag was already valid. It is 0 in every other clock.
- R11: During reset `pchk_n_o` = 1, `mc_valid_o` = 0, `mc_req_o` = 0, and the machine-check registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_i | input | LANES*8 | Returned read data |
| par_i | input | LANES | Parity bit for each byte lane |
| byte_en_i | input | LANES | Marks the lanes that carry valid data |
| rdy_i | input | 1 | Ready strobe: a transfer completes in this clock |
| rd_i | input | 1 | 1 for a read cycle, 0 for a write |
| addr_i | input | ADDR_W | Address of the current cycle |
| ctl_i | input | CTL_W | Control bits of the current cycle |
| par_en_i | input | 1 | Parity enable, sampled in the error clock |
| mce_i | input | 1 | Machine-check enable configuration bit |
| mc_clr_i | input | 1 | Software clear of the valid flag |
| pchk_n_o | output | 1 | Active-low parity check result |
| mc_addr_o | output | ADDR_W | Captured address |
| mc_ctl_o | output | CTL_W | Captured control |
| mc_valid_o | output | 1 | Machine-check registers hold a capture |
| mc_req_o | output | 1 | Machine-check request pulse |

## Verification
Directed reads flip parity on one lane, on two lanes, and on no lane. This shows that each lane is checked on its own and that a clean transfer gives no result. The same bad parity is then applied on a disabled lane, on a write, and in a clock without the ready strobe, which separates the lane and cycle qualifiers from the parity test itself. Runs of back-to-back errors test whether the pipeline keeps one result per transfer. The parity-enable, machine-check-enable and clear inputs are tried in every combination, including a clear in the same clock as an error, followed by a long random phase. A behavioural model compares every output on every clock.

// File: rtl/rd_parity_chk.sv
module rd_parity_chk #(
  parameter int LANES  = 8,
  parameter int ADDR_W = 32,
  parameter int CTL_W  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [LANES*8-1:0]  data_i,
  input  logic [LANES-1:0]    par_i,
  input  logic [LANES-1:0]    byte_en_i,
  input  logic                rdy_i,
  input  logic                rd_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [CTL_W-1:0]    ctl_i,
  input  logic                par_en_i,
  input  logic                mce_i,
  input  logic                mc_clr_i,
  output logic                pchk_n_o,
  output logic [ADDR_W-1:0]   mc_addr_o,
  output logic [CTL_W-1:0]    mc_ctl_o,
  output logic                mc_valid_o,
  output logic                mc_req_o
);

  logic [LANES-1:0] lane_bad;
  logic hit, take, stg1, stg2;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_bad[g] = byte_en_i[g] & (^{data_i[8*g +: 8], par_i[g]});
  end

  assign hit      = rdy_i & rd_i & (|lane_bad);
  assign take     = hit & par_en_i & (~mc_valid_o | mc_clr_i);
  assign pchk_n_o = ~stg2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg1     <= 1'b0;
      stg2     <= 1'b0;
      mc_req_o <= 1'b0;
    end else begin
      stg1     <= hit;
      stg2     <= stg1;
      mc_req_o <= hit & par_en_i & mce_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mc_valid_o <= 1'b0;
      mc_addr_o  <= '0;
      mc_ctl_o   <= '0;
    end else if (take) begin
      mc_valid_o <= 1'b1;
      mc_addr_o  <= addr_i;
      mc_ctl_o   <= ctl_i;
    end else if (mc_clr_i) begin
      mc_valid_o <= 1'b0;
    end
  end

endmodule

// File: rtl/rd_parity_chk_sva.sv
module rd_parity_chk_sva #(
  parameter int LANES  = 8,
  parameter int ADDR_W = 32,
  parameter int CTL_W  = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [LANES*8-1:0] data_i,
  input logic [LANES-1:0]   par_i,
  input logic [LANES-1:0]   byte_en_i,
  input logic               rdy_i,
  input logic               rd_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [CTL_W-1:0]   ctl_i,
  input logic               par_en_i,
  input logic               mce_i,
  input logic               mc_clr_i,
  input logic               pchk_n_o,
  input logic [ADDR_W-1:0]  mc_addr_o,
  input logic [CTL_W-1:0]   mc_ctl_o,
  input logic               mc_valid_o,
  input logic               mc_req_o
);
  logic [1:0] age;
  logic [LANES-1:0] bad;
  logic seen;

  always_comb begin
    for (int i = 0; i < LANES; i++)
      bad[i] = byte_en_i[i] && (^data_i[8*i +: 8]) != par_i[i];
  end
  assign seen = rdy_i && rd_i && (bad != '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) age <= 2'd0;
    else if (age != 2'd2) age <= age + 2'd1;

  // R2
  pchk_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd2) |-> (pchk_n_o == !$past(seen, 2)));

  // R2
  pchk_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age != 2'd2) |-> pchk_n_o);

  // R10
  req_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen && par_en_i && mce_i |=> mc_req_o);

  // R10
  req_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(seen && par_en_i && mce_i) |=> !mc_req_o);

  // R6
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen && par_en_i && !mc_valid_o |=> mc_valid_o && mc_addr_o == $past(addr_i) && mc_ctl_o == $past(ctl_i));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mc_valid_o && !mc_clr_i |=> mc_valid_o && $stable(mc_addr_o) && $stable(mc_ctl_o));

  // R7
  no_pen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !par_en_i && !mc_clr_i |=> $stable(mc_valid_o) && $stable(mc_addr_o));
endmodule

bind rd_parity_chk rd_parity_chk_sva #(.LANES(LANES), .ADDR_W(ADDR_W), .CTL_W(CTL_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .data_i(data_i), .par_i(par_i), .byte_en_i(byte_en_i),
  .rdy_i(rdy_i), .rd_i(rd_i), .addr_i(addr_i), .ctl_i(ctl_i), .par_en_i(par_en_i),
  .mce_i(mce_i), .mc_clr_i(mc_clr_i), .pchk_n_o(pchk_n_o), .mc_addr_o(mc_addr_o),
  .mc_ctl_o(mc_ctl_o), .mc_valid_o(mc_valid_o), .mc_req_o(mc_req_o));

// File: tb/rd_parity_chk_test.sv
module rd_parity_chk_test;
  localparam int LANES = 8, ADDR_W = 32, CTL_W = 4;

  logic clk = 0, rst_n = 0;
  logic [LANES*8-1:0] data_i = '0;
  logic [LANES-1:0] par_i = '0, byte_en_i = '0;
  logic rdy_i = 0, rd_i = 0, par_en_i = 0, mce_i = 0, mc_clr_i = 0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [CTL_W-1:0] ctl_i = '0;
  logic pchk_n_o, mc_valid_o, mc_req_o;
  logic [ADDR_W-1:0] mc_addr_o;
  logic [CTL_W-1:0] mc_ctl_o;

  rd_parity_chk #(.LANES(LANES), .ADDR_W(ADDR_W), .CTL_W(CTL_W)) uut (.*);

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  string tag = "R11";
  int pipe[$];
  bit m_valid = 0, m_req = 0;
  logic [ADDR_W-1:0] m_addr = '0;
  logic [CTL_W-1:0] m_ctl = '0;

  task automatic chk(string t, string what, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %0h exp %0h", t, what, got, exp);
    end
  endtask

  task automatic compare();
    chk(tag, "pchk_n_o", 64'(pchk_n_o), 64'(!pipe[0]));
    chk(tag, "mc_valid_o", 64'(mc_valid_o), 64'(m_valid));
    chk(tag, "mc_addr_o", 64'(mc_addr_o), 64'(m_addr));
    chk(tag, "mc_ctl_o", 64'(mc_ctl_o), 64'(m_ctl));
    chk(tag, "mc_req_o", 64'(mc_req_o), 64'(m_req));
  endtask

  function automatic bit ref_hit();
    bit e = 0;
    for (int i = 0; i < LANES; i++) begin
      int ones = 0;
      for (int b = 0; b < 8; b++) ones += data_i[8*i+b];
      ones += par_i[i];
      if (byte_en_i[i] && (ones % 2 == 1)) e = 1;
    end
    return e && rdy_i && rd_i;
  endfunction

  task automatic step();
    bit h;
    @(posedge clk);
    h = ref_hit();
    void'(pipe.pop_front());
    pipe.push_back(int'(h));
    m_req = h && par_en_i && mce_i;
    if (h && par_en_i && (!m_valid || mc_clr_i)) begin
      m_valid = 1; m_addr = addr_i; m_ctl = ctl_i;
    end else if (mc_clr_i) m_valid = 0;
    @(negedge clk);
    compare();
  endtask

  task automatic xfer(bit rdy, bit rd, logic [LANES-1:0] be, logic [LANES-1:0] flip,
                      bit pen, bit mce, bit clr);
    logic [LANES-1:0] p;
    data_i = {$urandom, $urandom};
    for (int i = 0; i < LANES; i++) p[i] = ^data_i[8*i +: 8];
    par_i = p ^ flip;
    rdy_i = rdy; rd_i = rd; byte_en_i = be;
    par_en_i = pen; mce_i = mce; mc_clr_i = clr;
    addr_i = $urandom; ctl_i = CTL_W'($urandom);
    step();
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) xfer(0, 0, '0, '0, 0, 0, 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    pipe = '{0, 0};
    repeat (3) @(negedge clk);
    compare();
    rst_n = 1;
    tag = "R1";  xfer(1, 1, 8'hFF, 8'h00, 0, 0, 0);
    xfer(1, 1, 8'hFF, 8'h01, 0, 0, 0); idle(2);
    xfer(1, 1, 8'hFF, 8'h81, 0, 0, 0); idle(2);
    tag = "R3";  xfer(1, 1, 8'hDF, 8'h20, 0, 0, 0); idle(2);
    xfer(1, 1, 8'h20, 8'h20, 0, 0, 0); idle(2);
    tag = "R4";  xfer(1, 0, 8'hFF, 8'hFF, 0, 0, 0); idle(2);
    xfer(0, 1, 8'hFF, 8'hFF, 1, 1, 0); idle(2);
    tag = "R5";  xfer(1, 1, 8'hFF, 8'h02, 0, 0, 0);
    xfer(1, 1, 8'hFF, 8'h40, 0, 0, 0);
    xfer(1, 1, 8'hFF, 8'h00, 0, 0, 0);
    xfer(1, 1, 8'hFF, 8'h10, 0, 0, 0); idle(3);
    tag = "R7";  xfer(1, 1, 8'hFF, 8'h04, 0, 1, 0); idle(2);
    tag = "R6";  xfer(1, 1, 8'hFF, 8'h08, 1, 0, 0); idle(2);
    tag = "R8";  xfer(1, 1, 8'hFF, 8'h01, 1, 0, 0); idle(2);
    tag = "R10"; xfer(1, 1, 8'hFF, 8'h02, 1, 1, 0);
    xfer(1, 1, 8'hFF, 8'h02, 0, 1, 0);
    xfer(1, 1, 8'hFF, 8'h00, 1, 1, 0); idle(2);
    tag = "R9";  xfer(0, 0, 8'h00, 8'h00, 0, 0, 1); idle(1);
    xfer(1, 1, 8'hFF, 8'h80, 1, 1, 0); idle(1);
    xfer(1, 1, 8'hFF, 8'h01, 1, 0, 1); idle(3);
    tag = "RND";
    for (int k = 0; k < 2000; k++)
      xfer($urandom_range(0, 3) != 0, $urandom_range(0, 3) != 0, LANES'($urandom),
           ($urandom_range(0, 2) == 0) ? LANES'($urandom) : '0,
           $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 9) == 0);
    idle(3);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule